// File: doc/BRIEF.md
# Internal-RAM Subroutine Return Stack

This block is the call/return controller of a small microcontroller. It does not own a register file for return addresses. Return context lives in a fixed window of the on-chip data RAM: eight two-byte slots starting at byte 08H. The block reaches that window through a plain synchronous RAM port, with one address, a write enable, write data and read data that arrive one clock after the address.

On a call the block stores the 12-bit program counter and four status bits into the slot the stack pointer selects. It then hands the core an 11-bit target address, with PC bit 11 kept from the calling context, and advances the pointer. On a return it reads the slot below the pointer back, low byte first. It restores only the program counter; the stored status nibble is dropped. It then moves the pointer down.

The pointer is three bits wide and wraps in both directions. Nesting deeper than eight levels therefore overwrites the oldest entry without any warning. The block accepts one operation at a time and raises `busy_o` while an operation is in flight.

Top module: `ram_ret_stack`

## Requirements
- R1: After reset the stack pointer is 0, and `busy_o`, `pc_load_o` and `ram_we_o` are all 0.
- R2: In the cycle a call is accepted, the block writes PC[7:0] to byte address 08H + 2*SP.
- R3: In the cycle after acceptance, the block writes the byte {status[3:0], PC[11:8]} to byte address 09H + 2*SP, where status sits in bits 7:4.
- R4: In that second call cycle `pc_load_o` is 1 and `pc_new_o` equals {PC[11] at the call, target[10:0]}. After that cycle SP has risen by one.
- R5: An accepted return addresses slot SP-1. It reads the low byte in the acceptance cycle and the high byte in the next cycle. Two cycles after acceptance `pc_load_o` is 1 and `pc_new_o` equals {high[3:0], low[7:0]}, with the high nibble of the stored byte discarded. After that cycle SP has fallen by one.
- R6: SP wraps modulo 8. A call at SP 7 uses bytes 16H/17H and leaves SP at 0. A return at SP 0 reads bytes 16H/17H and leaves SP at 7. No RAM write ever falls outside 08H..17H.
- R7: Call and return strobes that arrive while `busy_o` is 1 are ignored. They cause no RAM write, no PC load and no change of SP.
- R8: When call and return are both asserted while idle, the call is performed and the return is dropped.
- R9: Each operation raises `pc_load_o` for exactly one cycle, and a return never writes the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Call request strobe |
| call_tgt_i | input | 11 | Call target address bits 10:0 |
| ret_i | input | 1 | Return request strobe |
| pc_i | input | 12 | Return address to save on a call |
| stat_i | input | 4 | Status bits saved with the return address |
| busy_o | output | 1 | Operation in progress, strobes ignored |
| sp_o | output | 3 | Current stack pointer |
| pc_load_o | output | 1 | One-cycle strobe: load `pc_new_o` into the PC |
| pc_new_o | output | 12 | New program counter value |
| ram_addr_o | output | 6 | Data RAM byte address |
| ram_we_o | output | 1 | Data RAM write enable |
| ram_wdata_o | output | 8 | Data RAM write data |
| ram_rdata_i | input | 8 | Data RAM read data, one cycle after address |

## Verification
The calls use return addresses with PC bit 11 both set and clear, and targets at both ends of the 11-bit range. This separates a correctly kept bit 11 from one taken from the target or the old PC. The status values are asymmetric, so a swapped nibble or a status leak into the restored PC shows up in the comparison.

A return from an empty stack reads from a preloaded slot 7. This tells correct underflow wrapping apart from a clamped pointer. A nine-deep run of calls and returns checks LIFO order across the overflow. Strobes asserted during busy cycles, and a cycle with both strobes at once, separate correct ignoring and call priority from double-accepted operations.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_CALL_HI = 2'd1,
      ST_RET_HI  = 2'd2,
      ST_RET_END = 2'd3
   } rstk_state_e;

endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr #(
   parameter int DEPTH = 8,
   localparam int SP_W = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc_i,
   input  logic            dec_i,
   output logic [SP_W-1:0] sp_o,
   output logic [SP_W-1:0] sp_prev_o
);

   logic [SP_W-1:0] sp_q;
   logic [SP_W-1:0] sp_next;

   generate
      if ((1 << SP_W) == DEPTH) begin : g_pow2
         // natural binary wrap
         assign sp_next   = sp_q + SP_W'(1);
         assign sp_prev_o = sp_q - SP_W'(1);
      end else begin : g_mod
         assign sp_next   = (sp_q == SP_W'(DEPTH - 1)) ? '0 : sp_q + SP_W'(1);
         assign sp_prev_o = (sp_q == '0) ? SP_W'(DEPTH - 1) : sp_q - SP_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else if (inc_i) begin
         sp_q <= sp_next;
      end else if (dec_i) begin
         sp_q <= sp_prev_o;
      end
   end

   assign sp_o = sp_q;

endmodule

// File: rtl/rstk_addr.sv
module rstk_addr #(
   parameter int ADDR_W = 6,
   parameter int BASE   = 8,
   parameter int SP_W   = 3
) (
   input  logic [SP_W-1:0]   slot_i,
   input  logic              hi_i,
   output logic [ADDR_W-1:0] addr_o
);

   // each slot spans two consecutive bytes: low half then high half
   assign addr_o = ADDR_W'(BASE) + ADDR_W'({slot_i, hi_i});

endmodule

// File: rtl/rstk_pack.sv
module rstk_pack #(
   parameter int PC_W   = 12,
   parameter int DATA_W = 8,
   parameter int STAT_W = 4,
   localparam int PCH_W = PC_W - DATA_W,
   localparam int PAD_W = DATA_W - STAT_W - PCH_W
) (
   input  logic [PC_W-1:0]   pc_i,
   input  logic [STAT_W-1:0] stat_i,
   output logic [DATA_W-1:0] lo_o,
   output logic [DATA_W-1:0] hi_o,
   input  logic [DATA_W-1:0] rd_lo_i,
   input  logic [PCH_W-1:0]  rd_pch_i,
   output logic [PC_W-1:0]   pc_o
);

   assign lo_o = pc_i[DATA_W-1:0];

   generate
      if (PAD_W == 0) begin : g_full
         assign hi_o = {stat_i, pc_i[PC_W-1:DATA_W]};
      end else begin : g_pad
         assign hi_o = {{PAD_W{1'b0}}, stat_i, pc_i[PC_W-1:DATA_W]};
      end
   endgenerate

   // restore only the PC; status bits of the slot are dropped
   assign pc_o = {rd_pch_i, rd_lo_i};

endmodule

// File: rtl/ram_ret_stack.sv
module ram_ret_stack
   import rstk_pkg::*;
#(
   parameter int PC_W   = 12,
   parameter int TGT_W  = 11,
   parameter int DATA_W = 8,
   parameter int STAT_W = 4,
   parameter int ADDR_W = 6,
   parameter int DEPTH  = 8,
   parameter int BASE   = 8,
   localparam int SP_W  = $clog2(DEPTH),
   localparam int PCH_W = PC_W - DATA_W,
   localparam int TOP_W = PC_W - TGT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_i,
   input  logic [TGT_W-1:0]  call_tgt_i,
   input  logic              ret_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [STAT_W-1:0] stat_i,
   output logic              busy_o,
   output logic [SP_W-1:0]   sp_o,
   output logic              pc_load_o,
   output logic [PC_W-1:0]   pc_new_o,
   output logic [ADDR_W-1:0] ram_addr_o,
   output logic              ram_we_o,
   output logic [DATA_W-1:0] ram_wdata_o,
   input  logic [DATA_W-1:0] ram_rdata_i
);

   // elaboration-time parameter checks
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ram_ret_stack: DEPTH must be at least 2");
      end
      if (TOP_W < 1) begin : g_bad_tgt
         $error("ram_ret_stack: PC_W must exceed TGT_W");
      end
      if (PCH_W < 1 || STAT_W < 1 || PCH_W + STAT_W > DATA_W) begin : g_bad_pack
         $error("ram_ret_stack: PC high part and status must share one byte");
      end
      if (BASE + 2 * DEPTH > (1 << ADDR_W)) begin : g_bad_window
         $error("ram_ret_stack: stack window exceeds RAM address space");
      end
   endgenerate

   rstk_state_e       state_q;
   logic [SP_W-1:0]   sp;
   logic [SP_W-1:0]   sp_prev;
   logic [SP_W-1:0]   slot_q;
   logic [TGT_W-1:0]  tgt_q;
   logic [TOP_W-1:0]  top_q;
   logic [DATA_W-1:0] hi_q;
   logic [DATA_W-1:0] lo_q;
   logic [SP_W-1:0]   slot_sel;
   logic              hi_sel;
   logic [DATA_W-1:0] pk_lo;
   logic [DATA_W-1:0] pk_hi;
   logic [PC_W-1:0]   up_pc;
   logic              idle;
   logic              unused_rd_bits;

   assign idle           = (state_q == ST_IDLE);
   assign unused_rd_bits = ^ram_rdata_i[DATA_W-1:PCH_W];

   rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (state_q == ST_CALL_HI),
      .dec_i     (state_q == ST_RET_END),
      .sp_o      (sp),
      .sp_prev_o (sp_prev)
   );

   rstk_pack #(.PC_W(PC_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_pack (
      .pc_i     (pc_i),
      .stat_i   (stat_i),
      .lo_o     (pk_lo),
      .hi_o     (pk_hi),
      .rd_lo_i  (lo_q),
      .rd_pch_i (ram_rdata_i[PCH_W-1:0]),
      .pc_o     (up_pc)
   );

   rstk_addr #(.ADDR_W(ADDR_W), .BASE(BASE), .SP_W(SP_W)) u_addr (
      .slot_i (slot_sel),
      .hi_i   (hi_sel),
      .addr_o (ram_addr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
         tgt_q   <= '0;
         top_q   <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (call_i) begin
                  // call has priority over a simultaneous return
                  state_q <= ST_CALL_HI;
                  slot_q  <= sp;
                  tgt_q   <= call_tgt_i;
                  top_q   <= pc_i[PC_W-1:TGT_W];
                  hi_q    <= pk_hi;
               end else if (ret_i) begin
                  state_q <= ST_RET_HI;
                  slot_q  <= sp_prev;
               end
            end
            ST_CALL_HI: state_q <= ST_IDLE;
            ST_RET_HI: begin
               lo_q    <= ram_rdata_i;
               state_q <= ST_RET_END;
            end
            ST_RET_END: state_q <= ST_IDLE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      slot_sel    = sp;
      hi_sel      = 1'b0;
      ram_we_o    = 1'b0;
      ram_wdata_o = pk_lo;
      pc_load_o   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (call_i) begin
               ram_we_o = 1'b1;
            end else if (ret_i) begin
               slot_sel = sp_prev;
            end
         end
         ST_CALL_HI: begin
            slot_sel    = slot_q;
            hi_sel      = 1'b1;
            ram_we_o    = 1'b1;
            ram_wdata_o = hi_q;
            pc_load_o   = 1'b1;
         end
         ST_RET_HI: begin
            slot_sel = slot_q;
            hi_sel   = 1'b1;
         end
         ST_RET_END: begin
            slot_sel  = slot_q;
            hi_sel    = 1'b1;
            pc_load_o = 1'b1;
         end
         default: begin
            slot_sel = sp;
         end
      endcase
   end

   assign pc_new_o = (state_q == ST_RET_END) ? up_pc : {top_q, tgt_q};
   assign busy_o   = !idle;
   assign sp_o     = sp;

endmodule

module ram_ret_stack_chk #(
   parameter int ADDR_W = 6,
   parameter int SP_W   = 3,
   parameter int BASE   = 8,
   parameter int DEPTH  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              call_i,
   input logic              ret_i,
   input logic              busy_o,
   input logic              pc_load_o,
   input logic              ram_we_o,
   input logic [ADDR_W-1:0] ram_addr_o,
   input logic [SP_W-1:0]   sp_o
);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !pc_load_o);

   p_call_hi_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && call_i) |=> (ram_we_o && ram_addr_o == $past(ram_addr_o) + ADDR_W'(1)));

   p_call_sp_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load_o && ram_we_o) |=> (sp_o == $past(sp_o) + SP_W'(1)));

   p_ret_sp_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load_o && !ram_we_o) |=> (sp_o == $past(sp_o) - SP_W'(1)));

   p_write_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |-> (int'(ram_addr_o) >= BASE && int'(ram_addr_o) < BASE + 2 * DEPTH));

   p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !pc_load_o) |=> ($stable(sp_o) && busy_o));

   p_load_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |=> !pc_load_o);

   p_ret_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && ret_i && !call_i) |=> !ram_we_o);

endmodule

bind ram_ret_stack ram_ret_stack_chk #(
   .ADDR_W (ADDR_W),
   .SP_W   (SP_W),
   .BASE   (BASE),
   .DEPTH  (DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .call_i     (call_i),
   .ret_i      (ret_i),
   .busy_o     (busy_o),
   .pc_load_o  (pc_load_o),
   .ram_we_o   (ram_we_o),
   .ram_addr_o (ram_addr_o),
   .sp_o       (sp_o)
);

// File: tb/ram_ret_stack_test.sv
`timescale 1ns/1ps
module ram_ret_stack_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_i = 1'b0;
   logic [10:0] call_tgt_i = '0;
   logic        ret_i = 1'b0;
   logic [11:0] pc_i = '0;
   logic [3:0]  stat_i = '0;
   logic        busy_o;
   logic [2:0]  sp_o;
   logic        pc_load_o;
   logic [11:0] pc_new_o;
   logic [5:0]  ram_addr_o;
   logic        ram_we_o;
   logic [7:0]  ram_wdata_o;
   logic [7:0]  ram_rdata_i = '0;

   int total = 0;
   int bad = 0;
   int sp_model = 0;
   bit finished = 0;

   logic [7:0] mem [64];

   int    w_addr_q[$];
   int    w_data_q[$];
   string w_tag_q[$];
   int    l_val_q[$];
   string l_tag_q[$];

   always #4 clk = ~clk;

   ram_ret_stack uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .call_i      (call_i),
      .call_tgt_i  (call_tgt_i),
      .ret_i       (ret_i),
      .pc_i        (pc_i),
      .stat_i      (stat_i),
      .busy_o      (busy_o),
      .sp_o        (sp_o),
      .pc_load_o   (pc_load_o),
      .pc_new_o    (pc_new_o),
      .ram_addr_o  (ram_addr_o),
      .ram_we_o    (ram_we_o),
      .ram_wdata_o (ram_wdata_o),
      .ram_rdata_i (ram_rdata_i)
   );

   // bench-side synchronous RAM
   always @(posedge clk) begin
      if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;
      ram_rdata_i <= mem[ram_addr_o];
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // monitor: pop and compare expected writes and loads
   always @(negedge clk) begin : mon
      int    a;
      int    d;
      string t;
      #1;
      if (rst_n && !finished) begin
         if (ram_we_o) begin
            if (w_addr_q.size() == 0) begin
               total++;
               bad++;
               $display("FAIL R9/R7 unexpected write act=%0h exp=none", ram_addr_o);
            end else begin
               a = w_addr_q.pop_front();
               d = w_data_q.pop_front();
               t = w_tag_q.pop_front();
               chk({t, " write addr"}, ram_addr_o, a);
               chk({t, " write data"}, ram_wdata_o, d);
            end
         end
         if (pc_load_o) begin
            if (l_val_q.size() == 0) begin
               total++;
               bad++;
               $display("FAIL R9/R7 unexpected pc load act=%0h exp=none", pc_new_o);
            end else begin
               a = l_val_q.pop_front();
               t = l_tag_q.pop_front();
               chk({t, " pc_new"}, pc_new_o, a);
            end
         end
      end
   end

   // mode 0 plain, 1 strobes during busy (R7), 2 ret together with call (R8)
   task automatic do_call(input logic [11:0] pc, input logic [3:0] st,
                          input logic [10:0] tgt, input int mode, input string tag);
      int s;
      @(negedge clk);
      s = sp_model;
      w_addr_q.push_back(8 + 2 * s); w_data_q.push_back(int'(pc[7:0]));
      w_tag_q.push_back({tag, " R2"});
      w_addr_q.push_back(9 + 2 * s); w_data_q.push_back(int'({st, pc[11:8]}));
      w_tag_q.push_back({tag, " R3"});
      l_val_q.push_back(int'({pc[11], tgt}));
      l_tag_q.push_back({tag, " R4"});
      call_i = 1'b1; pc_i = pc; stat_i = st; call_tgt_i = tgt;
      ret_i = (mode == 2);
      @(negedge clk);
      call_i = 1'b0; ret_i = 1'b0;
      if (mode == 1) begin
         call_i = 1'b1; ret_i = 1'b1; pc_i = 12'hFFF; call_tgt_i = 11'h555;
      end
      @(negedge clk);
      call_i = 1'b0; ret_i = 1'b0;
      sp_model = (s + 1) % 8;
      #1 chk({tag, " R4 sp after call"}, sp_o, sp_model);
   endtask

   task automatic do_ret(input int mode, input string tag);
      int s;
      @(negedge clk);
      s = (sp_model + 7) % 8;
      l_val_q.push_back(int'({mem[9 + 2 * s][3:0], mem[8 + 2 * s]}));
      l_tag_q.push_back({tag, " R5"});
      ret_i = 1'b1;
      @(negedge clk);
      ret_i = 1'b0;
      if (mode == 1) begin call_i = 1'b1; ret_i = 1'b1; end
      @(negedge clk);
      call_i = 1'b0; ret_i = 1'b0;
      @(negedge clk);
      sp_model = s;
      #1 chk({tag, " R5 sp after return"}, sp_o, sp_model);
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL all act=timeout exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
      mem[8'h16] = 8'h34;
      mem[8'h17] = 8'h9B;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state, held in reset
      chk("R1 sp in reset", sp_o, 0);
      chk("R1 busy in reset", busy_o, 0);
      chk("R1 pc_load in reset", pc_load_o, 0);
      chk("R1 we in reset", ram_we_o, 0);
      @(negedge clk);
      rst_n = 1'b1;

      do_call(12'h8A5, 4'hC, 11'h123, 0, "callA");
      do_call(12'h3F0, 4'h5, 11'h7FF, 0, "callB");
      do_call(12'hC0E, 4'hA, 11'h001, 1, "callC R7");
      chk("R7 sp after busy strobes", sp_o, 3);
      do_ret(0, "retC");
      do_ret(1, "retB R7");
      chk("R7 sp after busy strobes on return", sp_o, 1);
      do_ret(0, "retA");
      // R6 underflow: return from empty stack reads slot 7 (16H/17H)
      do_ret(0, "ret empty R6");
      chk("R6 sp after underflow", sp_o, 7);
      do_call(12'h6D2, 4'h3, 11'h40A, 0, "call top R6");
      chk("R6 sp after overflow", sp_o, 0);
      chk("R6 slot7 low byte", mem[8'h16], 8'hD2);
      chk("R6 slot7 high byte", mem[8'h17], 8'h36);
      // R8 both strobes together
      do_call(12'h912, 4'h7, 11'h2B4, 2, "call+ret R8");
      chk("R8 sp after simultaneous", sp_o, 1);
      do_ret(0, "ret after R8");
      // nine-deep nesting with wrap, then unwind
      for (int k = 0; k < 9; k++) begin
         do_call(12'(k * 12'h1A3 + 12'h811), 4'(k + 2), 11'(k * 11'h0F1), 0, "deep R6");
      end
      for (int k = 0; k < 9; k++) begin
         do_ret(0, "unwind R6");
      end
      repeat (3) @(negedge clk);
      #1;
      chk("R9 pending loads", l_val_q.size(), 0);
      chk("R9 pending writes", w_addr_q.size(), 0);
      chk("R1 idle at end", busy_o, 0);
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule